// File: doc/BRIEF.md
# TDM Serial Port With Companding

A single time-division-multiplexed serial port for framers and voice codecs. A bit clock, a frame sync and one serial line in each direction come from the line side. Each frame is cut into a programmable number of equal time slots, and each slot carries one word of 2, 4, 8 or 16 bits, most significant bit first. On the parallel side, received words come out with the index of their slot. Transmit words are taken through a valid/ready handshake, one per slot.

For 8-bit slots an optional hardware stage converts between segmented logarithmic codes (A-law or μ-law) and 16-bit two's-complement linear samples. Received codes are expanded and transmitted samples are compressed. The bit clock, frame sync and serial input are sampled in the system clock domain, which must run at least four times faster than the bit clock. Several ports can run side by side, each with its own clock and framing.

Top module: `tdm_port`

## Requirements
- R1: While rst_ni is low, sd_o, rx_valid_o, tx_ready_o and underrun_o are all 0.
- R2: word_sel_i selects the slot word size: 0 gives 2 bits, 1 gives 4, 2 gives 8 and 3 gives 16. In linear mode each received word is shifted in MSB first and appears right-aligned and zero-extended on rx_data_o. This happens with a single-cycle rx_valid_o pulse after the rising bit-clock edge of the word's last bit.
- R3: The frame sync is sampled on rising bit-clock edges. With sync_dly_i=0, the bit sampled together with the sync is bit 0 of slot 0. With sync_dly_i=1, bit 0 of slot 0 is the next bit.
- R4: A frame holds slots_m1_i+1 slots (1 to 128), and rx_slot_o gives the slot index of each word. Bits after the last slot are ignored until the next sync.
- R5: Transmit bits change only on falling bit-clock edges, MSB first. Each bit is driven in the same bit period as the position it belongs to. In linear mode the word sent is the low word-size bits of tx_data_i. Outside a frame sd_o is 0.
- R6: tx_ready_o is a single-cycle pulse at the start of each slot. A word is taken when tx_valid_i is high in that cycle.
- R7: If tx_valid_i is low when a slot starts, the slot sends all ones and underrun_o pulses for one cycle.
- R8: With comp_mode_i=1 and 8-bit slots, A-law is used. Received codes are expanded to 16-bit linear samples and tx_data_i is compressed to an 8-bit code, with even bits inverted and the sign bit set for non-negative values.
- R9: With comp_mode_i=2 and 8-bit slots, μ-law is used. The bias is 132, the clip level is 32635, and the code is inverted, so sign bit 0 means negative.
- R10: The companding setting has no effect when the word size is not 8. Such slots behave as linear.
- R11: Before the first frame sync, serial input produces no received words and sd_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, synchronous to clk_i |
| fsync_i | input | 1 | Frame sync |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |
| word_sel_i | input | 2 | Word size select: 2, 4, 8 or 16 bits |
| slots_m1_i | input | 7 | Slots per frame minus one |
| sync_dly_i | input | 1 | Sync-to-data delay of 0 or 1 bit |
| comp_mode_i | input | 2 | 0 linear, 1 A-law, 2 μ-law, 3 linear |
| tx_data_i | input | 16 | Transmit sample |
| tx_valid_i | input | 1 | Transmit sample valid |
| tx_ready_o | output | 1 | Transmit sample taken at slot start |
| rx_data_o | output | 16 | Received sample |
| rx_slot_o | output | 7 | Slot index of received sample |
| rx_valid_o | output | 1 | Received sample valid |
| underrun_o | output | 1 | Slot started with no transmit sample |

## Verification
The bench builds the port with its default parameters: 128 slots and 16-bit samples. This makes the largest frame, 128 two-bit slots, reachable, and exercises the full 7-bit slot index. All four word sizes are run, both sync delays, and both companding laws at their clip and sign extremes. Companding is also requested on 16-bit slots to show that it is ignored. The A-law and μ-law expected codes and samples come from an independent loop-based model in the bench.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 8;

  typedef enum logic [1:0] {
    CMP_OFF  = 2'd0,
    CMP_ALAW = 2'd1,
    CMP_ULAW = 2'd2,
    CMP_RSVD = 2'd3
  } comp_mode_e;

  function automatic logic [4:0] word_len(input logic [1:0] sel);
    return 5'd2 << sel;
  endfunction
endpackage

// File: rtl/tdm_frame_ctl.sv
`timescale 1ns/1ps
module tdm_frame_ctl #(
  parameter int SLOT_W = 7,
  parameter int BIT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              sd_i,
  input  logic              sync_dly_i,
  input  logic [SLOT_W-1:0] slots_m1_i,
  input  logic [BIT_W:0]    wlen_i,
  output logic              tick_o,
  output logic              fall_o,
  output logic              act_o,
  output logic              first_o,
  output logic              last_o,
  output logic              sd_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o
);
  logic bclk_q, pend_q, act_q, sd_q, tick_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic rise, at_last;

  assign rise    = bclk_i & ~bclk_q;
  assign fall_o  = bclk_q & ~bclk_i;
  assign at_last = ({1'b0, bit_q} == (wlen_i - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      tick_q <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      sd_q   <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
    end else begin
      bclk_q <= bclk_i;
      tick_q <= rise;
      if (rise) begin
        sd_q <= sd_i;
        if (fsync_i) begin
          pend_q <= sync_dly_i;
          act_q  <= ~sync_dly_i;
          slot_q <= '0;
          bit_q  <= '0;
        end else if (pend_q) begin
          pend_q <= 1'b0;
          act_q  <= 1'b1;
          slot_q <= '0;
          bit_q  <= '0;
        end else if (act_q) begin
          if (at_last) begin
            bit_q <= '0;
            if (slot_q == slots_m1_i) act_q <= 1'b0;
            else slot_q <= slot_q + 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign tick_o  = tick_q;
  assign act_o   = act_q;
  assign first_o = act_q & (bit_q == '0);
  assign last_o  = act_q & at_last;
  assign sd_o    = sd_q;
  assign slot_o  = slot_q;
  assign bit_o   = bit_q;
endmodule

// File: rtl/tdm_codec.sv
`timescale 1ns/1ps
module tdm_codec
  import tdm_pkg::*;
(
  input  logic                alaw_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic [SAMPLE_W-1:0] lin_o,
  input  logic [SAMPLE_W-1:0] lin_i,
  output logic [CODE_W-1:0]   code_o
);
  // expansion
  logic [7:0]  av, uv;
  logic [15:0] at, ut, a_lin, u_lin;
  always_comb begin
    av = code_i ^ 8'h55;
    at = {8'h00, av[3:0], 4'h8};
    if (av[6:4] != 3'd0) at = (at + 16'h0100) << (av[6:4] - 3'd1);
    a_lin = av[7] ? at : (16'h0000 - at);
    uv = ~code_i;
    ut = ({9'h000, uv[3:0], 3'b000} + 16'h0084) << uv[6:4];
    u_lin = uv[7] ? (16'h0084 - ut) : (ut - 16'h0084);
    lin_o = alaw_i ? a_lin : u_lin;
  end

  // compression
  logic        apos, uneg;
  logic [11:0] amag;
  logic [2:0]  aseg, useg;
  logic [3:0]  amant, umant;
  logic [15:0] umag, ux;
  logic [7:0]  a_code, u_code;
  always_comb begin
    apos = ~lin_i[15];
    amag = apos ? lin_i[14:3] : ~lin_i[14:3];
    aseg = 3'd0;
    for (int i = 5; i < 12; i++) if (amag[i]) aseg = 3'(i - 4);
    amant  = (aseg == 3'd0) ? amag[4:1] : 4'(amag >> aseg);
    a_code = {1'b0, aseg, amant} ^ (apos ? 8'hD5 : 8'h55);

    uneg = lin_i[15];
    umag = uneg ? (16'h0000 - lin_i) : lin_i;
    if (umag > 16'd32635) umag = 16'd32635;
    ux   = umag + 16'h0084;
    useg = 3'd0;
    for (int i = 8; i < 15; i++) if (ux[i]) useg = 3'(i - 7);
    umant  = 4'(ux >> ({1'b0, useg} + 4'd3));
    u_code = {1'b0, useg, umant} ^ (uneg ? 8'h7F : 8'hFF);

    code_o = alaw_i ? a_code : u_code;
  end
endmodule

// File: rtl/tdm_rx.sv
`timescale 1ns/1ps
module tdm_rx
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 7,
  parameter int BIT_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                last_i,
  input  logic                sd_i,
  input  logic [BIT_W:0]      wlen_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                comp_en_i,
  input  logic [SAMPLE_W-1:0] lin_i,
  output logic [CODE_W-1:0]   code_o,
  output logic [SAMPLE_W-1:0] rx_data_o,
  output logic [SLOT_W-1:0]   rx_slot_o,
  output logic                rx_valid_o
);
  logic [SAMPLE_W-2:0] sh_q;
  logic [SAMPLE_W-1:0] word_nx, mask;

  assign word_nx = {sh_q, sd_i};
  assign mask    = {SAMPLE_W{1'b1}} >> (5'(SAMPLE_W) - wlen_i);
  assign code_o  = word_nx[CODE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      rx_data_o  <= '0;
      rx_slot_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= tick_i & last_i;
      if (tick_i) sh_q <= word_nx[SAMPLE_W-2:0];
      if (tick_i && last_i) begin
        rx_data_o <= comp_en_i ? lin_i : (word_nx & mask);
        rx_slot_o <= slot_i;
      end
    end
  end
endmodule

// File: rtl/tdm_tx.sv
`timescale 1ns/1ps
module tdm_tx
  import tdm_pkg::*;
#(
  parameter int BIT_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                fall_i,
  input  logic                act_i,
  input  logic                first_i,
  input  logic [BIT_W-1:0]    bit_i,
  input  logic [BIT_W:0]      wlen_i,
  input  logic                comp_en_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [SAMPLE_W-1:0] tx_data_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  output logic                underrun_o,
  output logic                sd_o
);
  logic [SAMPLE_W-1:0] txw_q;
  logic [BIT_W-1:0]    idx;

  assign tx_ready_o = tick_i & first_i;
  assign idx        = BIT_W'(SAMPLE_W - 1) - bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txw_q      <= '0;
      underrun_o <= 1'b0;
      sd_o       <= 1'b0;
    end else begin
      underrun_o <= tx_ready_o & ~tx_valid_i;
      if (tx_ready_o) begin
        if (!tx_valid_i)    txw_q <= '1;
        else if (comp_en_i) txw_q <= {code_i, {(SAMPLE_W-CODE_W){1'b0}}};
        else                txw_q <= tx_data_i << (5'(SAMPLE_W) - wlen_i);
      end
      if (fall_i) sd_o <= act_i & txw_q[idx];
    end
  end
endmodule

// File: rtl/tdm_port.sv
`timescale 1ns/1ps
module tdm_port
  import tdm_pkg::*;
#(
  parameter int MAX_SLOTS = 128
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bclk_i,
  input  logic                           fsync_i,
  input  logic                           sd_i,
  output logic                           sd_o,
  input  logic [1:0]                     word_sel_i,
  input  logic [$clog2(MAX_SLOTS)-1:0]   slots_m1_i,
  input  logic                           sync_dly_i,
  input  logic [1:0]                     comp_mode_i,
  input  logic [SAMPLE_W-1:0]            tx_data_i,
  input  logic                           tx_valid_i,
  output logic                           tx_ready_o,
  output logic [SAMPLE_W-1:0]            rx_data_o,
  output logic [$clog2(MAX_SLOTS)-1:0]   rx_slot_o,
  output logic                           rx_valid_o,
  output logic                           underrun_o
);
  localparam int SLOT_W = $clog2(MAX_SLOTS);
  localparam int BIT_W  = $clog2(SAMPLE_W);

  logic [BIT_W:0]      wlen;
  logic                comp_en, alaw;
  logic                tick, fall, act, first, last, sd_smp;
  logic [SLOT_W-1:0]   slot;
  logic [BIT_W-1:0]    bitn;
  logic [CODE_W-1:0]   rx_code, tx_code;
  logic [SAMPLE_W-1:0] rx_lin;

  assign wlen    = word_len(word_sel_i);
  assign alaw    = (comp_mode_i == CMP_ALAW);
  assign comp_en = (wlen == 5'(CODE_W)) && (alaw || comp_mode_i == CMP_ULAW);

  tdm_frame_ctl #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) i_frame (
    .clk_i, .rst_ni, .bclk_i, .fsync_i, .sd_i, .sync_dly_i, .slots_m1_i,
    .wlen_i(wlen), .tick_o(tick), .fall_o(fall), .act_o(act),
    .first_o(first), .last_o(last), .sd_o(sd_smp), .slot_o(slot), .bit_o(bitn)
  );

  tdm_codec i_codec (
    .alaw_i(alaw), .code_i(rx_code), .lin_o(rx_lin),
    .lin_i(tx_data_i), .code_o(tx_code)
  );

  tdm_rx #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) i_rx (
    .clk_i, .rst_ni, .tick_i(tick), .last_i(last), .sd_i(sd_smp),
    .wlen_i(wlen), .slot_i(slot), .comp_en_i(comp_en), .lin_i(rx_lin),
    .code_o(rx_code), .rx_data_o, .rx_slot_o, .rx_valid_o
  );

  tdm_tx #(.BIT_W(BIT_W)) i_tx (
    .clk_i, .rst_ni, .tick_i(tick), .fall_i(fall), .act_i(act),
    .first_i(first), .bit_i(bitn), .wlen_i(wlen), .comp_en_i(comp_en),
    .code_i(tx_code), .tx_data_i, .tx_valid_i, .tx_ready_o, .underrun_o, .sd_o
  );
endmodule

// File: rtl/tdm_port_chk.sv
`timescale 1ns/1ps
module tdm_port_chk #(
  parameter int SLOT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bclk_i,
  input logic              sd_o,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic              underrun_o,
  input logic              rx_valid_o,
  input logic [1:0]        word_sel_i,
  input logic [15:0]       rx_data_o,
  input logic [SLOT_W-1:0] rx_slot_o,
  input logic [SLOT_W-1:0] slots_m1_i
);
  // R6
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |=> !tx_ready_o);
  // R7
  underrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> $past(tx_ready_o && !tx_valid_i));
  // R2
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R2
  rx_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && word_sel_i == 2'd0) |-> (rx_data_o[15:2] == 14'd0));
  // R4
  rx_slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_slot_o <= slots_m1_i));
  // R5
  tx_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> !$past(bclk_i));
endmodule

bind tdm_port tdm_port_chk #(.SLOT_W(SLOT_W)) i_chk (.*);

// File: tb/test_tdm_port.sv
`timescale 1ns/1ps
module test_tdm_port;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic bclk_i = 1'b0, fsync_i = 1'b0, sd_i = 1'b0, sync_dly_i = 1'b0;
  logic sd_o, tx_ready_o, rx_valid_o, underrun_o, tx_valid_i;
  logic [1:0] word_sel_i = 2'd0, comp_mode_i = 2'd0;
  logic [6:0] slots_m1_i = 7'd0, rx_slot_o;
  logic [15:0] tx_data_i, rx_data_o;

  tdm_port i_tdm_port (
    .clk_i(clk), .rst_ni, .bclk_i, .fsync_i, .sd_i, .sd_o, .word_sel_i,
    .slots_m1_i, .sync_dly_i, .comp_mode_i, .tx_data_i, .tx_valid_i,
    .tx_ready_o, .rx_data_o, .rx_slot_o, .rx_valid_o, .underrun_o
  );

  int checks = 0, errors = 0, und_seen = 0, seed = 7;
  logic [15:0] tx_q[$];
  int exp_slot_q[$], exp_data_q[$];
  string exp_req_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 'hFFFF;
  endfunction

  // independent reference companders
  function automatic int alaw_enc(input int x);
    int m, seg, mant;
    m = (x >= 0) ? x : -x - 1;
    m = m / 8;
    seg = 0;
    while (seg < 7 && m >= (32 << seg)) seg++;
    mant = (seg == 0) ? (m / 2) : ((m >> seg) & 15);
    return ((seg * 16) + mant) ^ ((x >= 0) ? 'hD5 : 'h55);
  endfunction

  function automatic int alaw_dec(input int c);
    int v, t, seg;
    v = c ^ 'h55;
    seg = (v >> 4) & 7;
    t = (v & 15) * 16 + 8;
    if (seg > 0) t = (t + 256) * (1 << (seg - 1));
    return ((v & 128) != 0) ? t : -t;
  endfunction

  function automatic int mulaw_enc(input int x);
    int m, seg, mant;
    m = (x < 0) ? -x : x;
    if (m > 32635) m = 32635;
    m = m + 132;
    seg = 0;
    while (m >= (256 << seg)) seg++;
    mant = (m >> (seg + 3)) & 15;
    return ((seg * 16) + mant) ^ ((x < 0) ? 'h7F : 'hFF);
  endfunction

  function automatic int mulaw_dec(input int c);
    int u, t;
    u = ~c & 255;
    t = ((u & 15) * 8 + 132) << ((u >> 4) & 7);
    return ((u & 128) != 0) ? (132 - t) : (t - 132);
  endfunction

  // monitor: rx scoreboard and underrun counter
  always @(negedge clk) begin
    if (rst_ni) begin
      if (underrun_o) und_seen++;
      if (rx_valid_o) begin
        if (exp_data_q.size() == 0) begin
          check(1'b0, "R11 R4 unexpected rx word", rx_data_o, 0);
        end else begin
          check(rx_data_o == exp_data_q[0][15:0] && rx_slot_o == exp_slot_q[0][6:0],
                exp_req_q[0], {rx_slot_o, rx_data_o}, (exp_slot_q[0] << 16) | (exp_data_q[0] & 'hFFFF));
          void'(exp_data_q.pop_front());
          void'(exp_slot_q.pop_front());
          void'(exp_req_q.pop_front());
        end
      end
    end
  end

  // transmit driver
  initial begin
    tx_valid_i = 1'b0;
    tx_data_i  = '0;
    forever begin
      @(negedge clk);
      if (tx_valid_i && tx_ready_o) begin
        @(negedge clk);
        void'(tx_q.pop_front());
      end
      if (tx_q.size() > 0) begin
        tx_valid_i = 1'b1;
        tx_data_i  = tx_q[0];
      end else begin
        tx_valid_i = 1'b0;
      end
    end
  end

  task automatic drive_bit(input bit fs, input bit d, input bit exp_sd, input string req);
    @(negedge clk);
    fsync_i = fs; sd_i = d; bclk_i = 1'b1;
    @(negedge clk); @(negedge clk);
    bclk_i = 1'b0;
    @(negedge clk); @(negedge clk);
    check(sd_o == exp_sd, req, sd_o, exp_sd);
  endtask

  task automatic frame(input int sel, input int ns, input bit dly, input int mode,
                       input int lead, input string req);
    int w, mask, rxw, txw, und_exp, und_base, x;
    bit comp;
    w = 2 << sel;
    mask = (1 << w) - 1;
    comp = (sel == 2) && (mode == 1 || mode == 2);
    und_exp = 0;
    @(negedge clk);
    word_sel_i = 2'(sel); slots_m1_i = 7'(ns - 1); sync_dly_i = dly; comp_mode_i = 2'(mode);
    und_base = und_seen;
    for (int i = 0; i < lead; i++) drive_bit(1'b0, next_rand() & 1, 1'b0, "R11 line idle before sync");
    if (dly) drive_bit(1'b1, 1'b1, 1'b0, "R3 delayed sync bit carries no data");
    for (int s = 0; s < ns; s++) begin
      rxw = next_rand() & mask;
      if (tx_q.size() > 0) begin
        x = $signed(tx_q[0]);
        if (comp) txw = (mode == 1) ? alaw_enc(x) : mulaw_enc(x);
        else txw = tx_q[0] & mask;
      end else begin
        txw = mask;
        und_exp++;
      end
      exp_slot_q.push_back(s);
      exp_data_q.push_back(comp ? ((mode == 1) ? alaw_dec(rxw) : mulaw_dec(rxw)) & 'hFFFF : rxw);
      exp_req_q.push_back({req, " rx word"});
      for (int b = 0; b < w; b++)
        drive_bit(s == 0 && b == 0 && !dly, 1'((rxw >> (w - 1 - b)) & 1),
                  1'((txw >> (w - 1 - b)) & 1), {req, " tx bit"});
    end
    drive_bit(1'b0, 1'b1, 1'b0, "R4 bit after last slot ignored");
    drive_bit(1'b0, 1'b0, 1'b0, "R4 bit after last slot ignored");
    check(und_seen - und_base == und_exp, "R7 underrun pulses", und_seen - und_base, und_exp);
    check(exp_data_q.size() == 0, "R2 all rx words delivered", exp_data_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sd_o == 1'b0 && rx_valid_o == 1'b0 && tx_ready_o == 1'b0 && underrun_o == 1'b0,
          "R1 reset outputs", {sd_o, rx_valid_o, tx_ready_o, underrun_o}, 0);
    rst_ni = 1'b1;

    // R11: traffic before any sync
    for (int i = 0; i < 4; i++) drive_bit(1'b0, 1'b1, 1'b0, "R11 no frame yet");

    for (int i = 0; i < 4; i++) tx_q.push_back(16'hA5C3 + 16'(i * 7));
    frame(2, 4, 1'b0, 0, 2, "R2 R5 R6 w8 linear");
    check(tx_q.size() == 0, "R6 one sample taken per slot", tx_q.size(), 0);

    for (int i = 0; i < 3; i++) tx_q.push_back(16'(next_rand()));
    frame(0, 3, 1'b1, 0, 1, "R3 R2 w2 sync delay 1");

    for (int i = 0; i < 5; i++) tx_q.push_back(16'(next_rand()));
    frame(1, 5, 1'b0, 0, 1, "R2 R5 w4");

    for (int i = 0; i < 2; i++) tx_q.push_back(16'(next_rand()));
    frame(3, 2, 1'b0, 0, 1, "R2 R5 w16");

    tx_q.push_back(16'h7FFF); tx_q.push_back(16'h8000);
    tx_q.push_back(16'h0000); tx_q.push_back(16'hFFF0);
    frame(2, 4, 1'b0, 1, 1, "R8 A-law");

    tx_q.push_back(16'h7FFF); tx_q.push_back(16'h8000);
    tx_q.push_back(16'h0001); tx_q.push_back(16'hC123);
    frame(2, 4, 1'b1, 2, 1, "R9 mu-law");

    tx_q.push_back(16'h1234); tx_q.push_back(16'hFEDC);
    frame(3, 2, 1'b0, 1, 1, "R10 companding ignored at w16");
    tx_q.push_back(16'h0009); tx_q.push_back(16'h0006);
    frame(1, 2, 1'b0, 2, 1, "R10 companding ignored at w4");

    tx_q.push_back(16'h000B);
    frame(1, 3, 1'b0, 0, 1, "R7 underrun idle ones");

    for (int i = 0; i < 128; i++) tx_q.push_back(16'(next_rand()));
    frame(0, 128, 1'b0, 0, 1, "R4 128 slots");
    check(tx_q.size() == 0, "R6 all 128 samples taken", tx_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule